// File: doc/BRIEF.md
# Card memory window address translator

This block sits between a host memory bus with 24-bit addresses and a removable card. Software programs up to five windows through a byte-wide write port. Each window holds three page values in 4 KB units: a first page, a last page and a page offset. It also holds flag bits that set data width, zero-wait operation, a wait-state count, attribute-versus-common space and write protection.

For every host access the block looks for an enabled window whose page range covers the access. It adds that window's offset to the host page to form the card address. It then reports the window's attributes. A write that lands in a protected window is stopped and flagged instead of being forwarded. Results are registered, so each access comes out one clock after it is sampled. Bus timing generation is not part of this block.

Top module: `cmw_xlate`

## Requirements
- R1: After synchronous reset, all outputs are zero and every window is disabled, so every sampled access misses.
- R2: Window w hits when bit w of the enable register is set (configuration address 40, bits 4:0, bit 0 for window 0) and first page ≤ host_addr[23:12] ≤ last page, with both limits inclusive.
- R3: On a hit, card_addr[23:12] = (host_addr[23:12] + offset page) mod 4096, and card_addr[11:0] = host_addr[11:0].
- R4: When several windows hit, the window with the lowest number is used, and its number appears on hit_win.
- R5: Window w's six bytes sit at configuration address 8·w + k. k=0 is the first-page low byte and k=1 its high byte (bits 3:0 are page bits 11:8, bit 6 is zero-wait, bit 7 is 16-bit width). k=2 is the last-page low byte and k=3 its high byte (bits 3:0 page, bits 7:6 wait count). k=4 is the offset low byte and k=5 its high byte (bits 3:0 page, bit 6 attribute space, bit 7 write protect).
- R6: On a hit, card_wide, card_zws, card_wait and card_attr carry the flags of the winning window.
- R7: A write that hits a protected window raises wp_block and leaves card_we low. A read of that window completes normally.
- R8: On a miss, win_miss is 1 and card_addr, hit_win, card_we, wp_block and all attribute outputs are 0.
- R9: Outputs reflect the access sampled on the previous clock edge. A cycle with host_valid low produces out_valid = 0 and all other outputs 0.
- R10: A configuration write takes effect for accesses sampled after the edge that stores it. An access sampled on the same edge still uses the old settings.
- R11: Writes to bytes k=6 and k=7 of any window, and to addresses above 40, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 6 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration byte data |
| host_valid | input | 1 | Host access present this cycle |
| host_write | input | 1 | Host access is a write |
| host_addr | input | 24 | Host byte address |
| out_valid | output | 1 | A result for a sampled access is present |
| win_miss | output | 1 | The access hit no window |
| hit_win | output | 3 | Number of the winning window |
| card_addr | output | 24 | Translated card address |
| card_we | output | 1 | Write forwarded to the card |
| wp_block | output | 1 | Write stopped by window protection |
| card_attr | output | 1 | Attribute space selected (0 = common) |
| card_wide | output | 1 | 16-bit data width |
| card_zws | output | 1 | Zero wait states requested |
| card_wait | output | 2 | Wait-state count |

## Verification
Accesses are placed one page below the first page, on the first page, on the last page and one page above the last page. These four cases separate inclusive bounds from exclusive ones and catch swapped comparisons. An offset that overflows page 4095 shows whether the sum wraps or saturates. Overlapping windows are run under several enable masks, which shows whether the lowest enabled window wins rather than the highest or the first one programmed. A long random mix of configuration writes, reserved-address writes, reads, writes and idle cycles is compared every clock against a behavioural model, and it exposes same-edge ordering faults between configuration and access.

// File: rtl/cmw_pkg.sv
package cmw_pkg;

    localparam int HADDR_W    = 24;
    localparam int PAGE_SHIFT = 12;
    localparam int PAGE_W     = HADDR_W - PAGE_SHIFT;
    localparam int WIN_STRIDE = 8;
    localparam int DATA_W     = 8;
    localparam int HI_PAGE_W  = PAGE_W - DATA_W;

    // Flag positions inside the high byte of each value
    localparam int BIT_ZWS    = 6;
    localparam int BIT_WIDE   = 7;
    localparam int BIT_WAIT_L = 6;
    localparam int BIT_ATTR   = 6;
    localparam int BIT_WP     = 7;

    typedef logic [PAGE_W-1:0] page_t;

    typedef enum logic [2:0] {
        BY_FIRST_LO = 3'd0,
        BY_FIRST_HI = 3'd1,
        BY_LAST_LO  = 3'd2,
        BY_LAST_HI  = 3'd3,
        BY_OFFS_LO  = 3'd4,
        BY_OFFS_HI  = 3'd5
    } win_byte_e;

    typedef struct packed {
        page_t first_pg;
        page_t last_pg;
        page_t offs_pg;
    } win_pages_t;

    typedef struct packed {
        logic       wide;
        logic       zws;
        logic [1:0] wait_cnt;
        logic       attr;
        logic       wp;
    } win_flags_t;

    function automatic page_t page_of(input logic [HADDR_W-1:0] a);
        return a[HADDR_W-1:PAGE_SHIFT];
    endfunction

    function automatic logic in_range(input page_t p, input page_t lo, input page_t hi);
        return (p >= lo) && (p <= hi);
    endfunction

endpackage

// File: rtl/cmw_cfg_regs.sv
module cmw_cfg_regs
    import cmw_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int CFG_AW  = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_we,
    input  logic [CFG_AW-1:0]           cfg_addr,
    input  logic [DATA_W-1:0]           cfg_wdata,
    output win_pages_t [NUM_WIN-1:0]    win_pages,
    output win_flags_t [NUM_WIN-1:0]    win_flags,
    output logic [NUM_WIN-1:0]          win_en
);

    localparam int SEL_W   = CFG_AW - 3;
    localparam int EN_ADDR = NUM_WIN * WIN_STRIDE;

    logic [SEL_W-1:0] win_sel;
    win_byte_e        byte_sel;

    assign win_sel  = cfg_addr[CFG_AW-1:3];
    assign byte_sel = win_byte_e'(cfg_addr[2:0]);

    genvar w;
    generate
        for (w = 0; w < NUM_WIN; w++) begin : g_win
            logic hit_w;
            assign hit_w = cfg_we && (win_sel == SEL_W'(w));

            always_ff @(posedge clk) begin
                if (rst) begin
                    win_pages[w] <= '0;
                    win_flags[w] <= '0;
                end else if (hit_w) begin
                    case (byte_sel)
                        BY_FIRST_LO: win_pages[w].first_pg[DATA_W-1:0] <= cfg_wdata;
                        BY_FIRST_HI: begin
                            win_pages[w].first_pg[PAGE_W-1:DATA_W] <= cfg_wdata[HI_PAGE_W-1:0];
                            win_flags[w].zws  <= cfg_wdata[BIT_ZWS];
                            win_flags[w].wide <= cfg_wdata[BIT_WIDE];
                        end
                        BY_LAST_LO:  win_pages[w].last_pg[DATA_W-1:0] <= cfg_wdata;
                        BY_LAST_HI: begin
                            win_pages[w].last_pg[PAGE_W-1:DATA_W] <= cfg_wdata[HI_PAGE_W-1:0];
                            win_flags[w].wait_cnt <= cfg_wdata[BIT_WAIT_L+1:BIT_WAIT_L];
                        end
                        BY_OFFS_LO:  win_pages[w].offs_pg[DATA_W-1:0] <= cfg_wdata;
                        BY_OFFS_HI: begin
                            win_pages[w].offs_pg[PAGE_W-1:DATA_W] <= cfg_wdata[HI_PAGE_W-1:0];
                            win_flags[w].attr <= cfg_wdata[BIT_ATTR];
                            win_flags[w].wp   <= cfg_wdata[BIT_WP];
                        end
                        default: ;
                    endcase
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            win_en <= '0;
        end else if (cfg_we && (cfg_addr == CFG_AW'(EN_ADDR))) begin
            win_en <= cfg_wdata[NUM_WIN-1:0];
        end
    end

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && (cfg_addr == CFG_AW'(EN_ADDR))) |=> $stable(win_en)); // R11

endmodule

// File: rtl/cmw_win_match.sv
module cmw_win_match
    import cmw_pkg::*;
#(
    parameter int NUM_WIN = 5
) (
    input  win_pages_t [NUM_WIN-1:0]      win_pages,
    input  logic [NUM_WIN-1:0]            win_en,
    input  page_t                         host_page,
    output logic [NUM_WIN-1:0]            hits,
    output page_t [NUM_WIN-1:0]           xlat_page
);

    genvar w;
    generate
        for (w = 0; w < NUM_WIN; w++) begin : g_cmp
            assign hits[w] = win_en[w] &&
                             in_range(host_page, win_pages[w].first_pg, win_pages[w].last_pg);
            // Sum truncated to the page width: wraps modulo the page count
            assign xlat_page[w] = host_page + win_pages[w].offs_pg;
        end
    endgenerate

endmodule

// File: rtl/cmw_prio_pick.sv
module cmw_prio_pick #(
    parameter int NUM_WIN = 5,
    parameter int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_WIN-1:0] hits,
    output logic [NUM_WIN-1:0] grant,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);

    assign grant = hits & (~hits + 1'b1);
    assign any   = |hits;

    always_comb begin
        idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && (any == (grant != '0))); // R4

    AST_GRANT_IDX: assert property (@(posedge clk) disable iff (rst)
        any |-> (grant[idx] && ((hits & (grant - 1'b1)) == '0))); // R4

endmodule

// File: rtl/cmw_xlate.sv
module cmw_xlate
    import cmw_pkg::*;
#(
    parameter int NUM_WIN = 5,
    localparam int CFG_AW = $clog2(NUM_WIN * WIN_STRIDE + 1),
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic                 host_valid,
    input  logic                 host_write,
    input  logic [HADDR_W-1:0]   host_addr,
    output logic                 out_valid,
    output logic                 win_miss,
    output logic [IDX_W-1:0]     hit_win,
    output logic [HADDR_W-1:0]   card_addr,
    output logic                 card_we,
    output logic                 wp_block,
    output logic                 card_attr,
    output logic                 card_wide,
    output logic                 card_zws,
    output logic [1:0]           card_wait
);

    typedef struct packed {
        logic               valid;
        logic               miss;
        logic [IDX_W-1:0]   win;
        logic [HADDR_W-1:0] addr;
        logic               we;
        logic               wp_block;
        win_flags_t         flags;
    } result_t;

    win_pages_t [NUM_WIN-1:0] win_pages;
    win_flags_t [NUM_WIN-1:0] win_flags;
    logic [NUM_WIN-1:0]       win_en;
    logic [NUM_WIN-1:0]       hits;
    logic [NUM_WIN-1:0]       grant;
    page_t [NUM_WIN-1:0]      xlat_page;
    logic [IDX_W-1:0]         pick;
    logic                     any_hit;
    win_flags_t               sel_flags;
    result_t                  res_d, res_q;

    cmw_cfg_regs #(.NUM_WIN(NUM_WIN), .CFG_AW(CFG_AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .win_pages (win_pages),
        .win_flags (win_flags),
        .win_en    (win_en)
    );

    cmw_win_match #(.NUM_WIN(NUM_WIN)) u_match (
        .win_pages (win_pages),
        .win_en    (win_en),
        .host_page (page_of(host_addr)),
        .hits      (hits),
        .xlat_page (xlat_page)
    );

    cmw_prio_pick #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_prio (
        .clk   (clk),
        .rst   (rst),
        .hits  (hits),
        .grant (grant),
        .idx   (pick),
        .any   (any_hit)
    );

    always_comb begin
        sel_flags = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (grant[i]) sel_flags = win_flags[i];
        end
    end

    always_comb begin
        res_d = '0;
        if (host_valid) begin
            res_d.valid = 1'b1;
            if (any_hit) begin
                res_d.win      = pick;
                res_d.addr     = {xlat_page[pick], host_addr[PAGE_SHIFT-1:0]};
                res_d.flags    = sel_flags;
                res_d.we       = host_write && !sel_flags.wp;
                res_d.wp_block = host_write &&  sel_flags.wp;
            end else begin
                res_d.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign win_miss  = res_q.miss;
    assign hit_win   = res_q.win;
    assign card_addr = res_q.addr;
    assign card_we   = res_q.we;
    assign wp_block  = res_q.wp_block;
    assign card_attr = res_q.flags.attr;
    assign card_wide = res_q.flags.wide;
    assign card_zws  = res_q.flags.zws;
    assign card_wait = res_q.flags.wait_cnt;

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        win_miss |-> (card_addr == '0 && !card_we && !wp_block && !card_attr &&
                      !card_wide && !card_zws && card_wait == '0 && hit_win == '0)); // R8

    AST_WP_NO_WE: assert property (@(posedge clk) disable iff (rst)
        !(wp_block && card_we)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!win_miss && !card_we && !wp_block && card_addr == '0)); // R9

    AST_LOW_PASS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !win_miss) |->
            card_addr[PAGE_SHIFT-1:0] == $past(host_addr[PAGE_SHIFT-1:0])); // R3

    AST_MISS_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
        win_miss |-> out_valid); // R8

endmodule

// File: tb/cmw_xlate_tb.sv
`timescale 1ns/1ps
module cmw_xlate_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [5:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic        host_valid;
    logic        host_write;
    logic [23:0] host_addr;
    logic        out_valid, win_miss, card_we, wp_block, card_attr, card_wide, card_zws;
    logic [2:0]  hit_win;
    logic [23:0] card_addr;
    logic [1:0]  card_wait;

    always #2.5 clk = ~clk;

    cmw_xlate u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
        .out_valid(out_valid), .win_miss(win_miss), .hit_win(hit_win), .card_addr(card_addr),
        .card_we(card_we), .wp_block(wp_block), .card_attr(card_attr), .card_wide(card_wide),
        .card_zws(card_zws), .card_wait(card_wait)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    bit    chk_on   = 0;
    bit    done     = 0;
    string cur_tag  = "R1";
    string exp_tag  = "R1";

    // Behavioural model: raw bytes per window plus enable mask
    int mb [5][8];
    int men;
    logic [36:0] exp_vec;

    function automatic logic [36:0] pack_out(
        input bit v, input bit m, input int w, input int a, input bit we, input bit wpb,
        input bit at, input bit wd, input bit z, input int wt);
        return {v, m, w[2:0], a[23:0], we, wpb, at, wd, z, wt[1:0], 1'b0};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_vec = '0;
            men = 0;
            for (int i = 0; i < 5; i++) for (int k = 0; k < 8; k++) mb[i][k] = 0;
        end else begin
            int hp, found;
            hp = int'(host_addr) >> 12;
            found = -1;
            for (int i = 0; i < 5; i++) begin
                int lo, hi;
                lo = ((mb[i][1] & 15) << 8) | mb[i][0];
                hi = ((mb[i][3] & 15) << 8) | mb[i][2];
                if (found < 0 && ((men >> i) & 1) == 1 && hp >= lo && hp <= hi) found = i;
            end
            if (!host_valid) begin
                exp_vec = '0;
            end else if (found < 0) begin
                exp_vec = pack_out(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
            end else begin
                int off, ca, wpf;
                off = ((mb[found][5] & 15) << 8) | mb[found][4];
                ca  = (((hp + off) & 4095) << 12) | (int'(host_addr) & 4095);
                wpf = (mb[found][5] >> 7) & 1;
                exp_vec = pack_out(1, 0, found, ca,
                                   host_write && wpf == 0, host_write && wpf == 1,
                                   ((mb[found][5] >> 6) & 1) == 1,
                                   ((mb[found][1] >> 7) & 1) == 1,
                                   ((mb[found][1] >> 6) & 1) == 1,
                                   (mb[found][3] >> 6) & 3);
            end
            if (cfg_we) begin
                int a;
                a = int'(cfg_addr);
                if (a == 40) men = int'(cfg_wdata) & 31;
                else if (a < 40 && (a % 8) < 6) mb[a / 8][a % 8] = int'(cfg_wdata);
            end
        end
        exp_tag = cur_tag;
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            logic [36:0] act;
            act = pack_out(out_valid, win_miss, int'(hit_win), int'(card_addr), card_we, wp_block,
                           card_attr, card_wide, card_zws, int'(card_wait));
            n_checks++;
            if (act !== exp_vec) begin
                n_errors++;
                $display("FAIL %s: actual %h expected %h (v,m,win,addr,we,wpb,attr,wide,zws,wait)",
                         exp_tag, act, exp_vec);
            end
        end
    end

    task automatic cyc(input bit cwe, input int ca, input int cd,
                       input bit hv, input bit hw, input int ha);
        cfg_we = cwe; cfg_addr = 6'(ca); cfg_wdata = 8'(cd);
        host_valid = hv; host_write = hw; host_addr = 24'(ha);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        cyc(1, a, d, 0, 0, 0);
    endtask

    task automatic acc(input bit w, input int a);
        cyc(0, 0, 0, 1, w, a);
    endtask

    task automatic set_win(input int w, input int lo, input int hi, input int off,
                           input int wide, input int zws, input int wt, input int at, input int wp);
        wr(w*8+0, lo & 255);
        wr(w*8+1, ((lo >> 8) & 15) | (zws << 6) | (wide << 7));
        wr(w*8+2, hi & 255);
        wr(w*8+3, ((hi >> 8) & 15) | (wt << 6));
        wr(w*8+4, off & 255);
        wr(w*8+5, ((off >> 8) & 15) | (at << 6) | (wp << 7));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        rst = 1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        host_valid = 0; host_write = 0; host_addr = 0;
        repeat (3) @(negedge clk);
        chk_on = 1;
        cur_tag = "R1";
        @(negedge clk);
        rst = 0;
        acc(0, 24'h000123); acc(1, 24'h100ABC); acc(0, 24'hFFFFFF); acc(1, 24'h3A5000);

        cur_tag = "R5";
        set_win(0, 12'h100, 12'h1FF, 12'h0A0, 1, 0, 1, 0, 0);
        wr(40, 8'h01);
        cur_tag = "R2";
        acc(0, 24'h0FFABC); acc(0, 24'h100ABC); acc(1, 24'h1FFABC); acc(0, 24'h200ABC);
        acc(0, 24'h180000);
        wr(40, 8'h00);
        acc(0, 24'h150000);
        wr(40, 8'h01);

        cur_tag = "R3";
        set_win(2, 12'h300, 12'h3FF, 12'hE00, 0, 1, 3, 1, 0);
        wr(40, 8'h05);
        acc(0, 24'h380FED); acc(0, 24'h3FF001); acc(1, 24'h300000);

        cur_tag = "R4";
        set_win(1, 12'h150, 12'h160, 12'h400, 0, 0, 2, 1, 0);
        set_win(3, 12'h150, 12'h160, 12'h800, 1, 1, 0, 0, 0);
        wr(40, 8'h0F); acc(0, 24'h155123);
        wr(40, 8'h0A); acc(0, 24'h155123);
        wr(40, 8'h08); acc(1, 24'h160FFF);
        wr(40, 8'h0E); acc(0, 24'h150000);

        cur_tag = "R6";
        set_win(4, 12'h800, 12'h8FF, 12'h010, 0, 1, 2, 1, 0);
        wr(40, 8'h10); acc(0, 24'h812345); acc(1, 24'h8FF000);

        cur_tag = "R7";
        wr(37, 8'hC0);
        acc(1, 24'h812345); acc(0, 24'h812345); acc(1, 24'h800000);

        cur_tag = "R8";
        acc(1, 24'h7FFFFF); acc(0, 24'h900000); acc(1, 24'h000000);

        cur_tag = "R9";
        acc(1, 24'h812345); cyc(0, 0, 0, 0, 1, 24'h812345); acc(0, 24'h812000);
        cyc(0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 1, 24'h7FFFFF);

        cur_tag = "R10";
        cyc(1, 40, 8'h00, 1, 0, 24'h812345);
        acc(0, 24'h812345);
        cyc(1, 40, 8'h10, 1, 0, 24'h812345);
        acc(0, 24'h812345);
        cyc(1, 36, 8'h77, 1, 0, 24'h812345);
        acc(0, 24'h812345);

        cur_tag = "R11";
        wr(6, 8'hFF); wr(7, 8'hFF); wr(38, 8'h55); wr(41, 8'h00); wr(63, 8'h00); wr(47, 8'h1F);
        acc(0, 24'h812345); acc(1, 24'h8AA000); acc(0, 24'h180000);

        cur_tag = "R2";
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r < 3) begin
                int a;
                a = (r == 0) ? 40 : int'($urandom_range(0, 63));
                cyc(1, a, int'($urandom_range(0, 255)), $urandom_range(0, 1) == 1,
                    $urandom_range(0, 1) == 1, int'($urandom) & 24'hFFFFFF);
            end else if (r < 5) begin
                cyc(0, 0, 0, 0, $urandom_range(0, 1) == 1, 0);
            end else begin
                acc($urandom_range(0, 1) == 1, int'($urandom) & 24'hFFFFFF);
            end
        end

        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule